// File: doc/BRIEF.md
# Idle-Delayed Clock Gating Controller

This block decides when a unit's functional clock may be gated. Gating starts only after the unit's idle indication has been held for a programmable minimum time. The block also decides when an auxiliary clock may be gated.

Time is measured in ticks. A tick is a one-cycle pulse from an external timebase with a 0.512 µs period. An 8-bit delay field sets how many whole tick periods must pass after idle rises. Once the delay is met, the local gate enable asserts first. The trunk gate enable follows one tick later. The auxiliary gate enable asserts together with the local enable.

A 2-bit mode field selects which levels of main-clock gating are allowed. A single bit disables auxiliary gating. When idle drops, every enable is removed at once, without waiting for a clock edge. While reset is held, no enable can be asserted.

The block carries no data stream, so all pins are plain control and status levels with no valid/ready handshake. Configuration inputs are expected to come from a register and may change at any time. A change of mode or of the auxiliary-disable bit takes effect on the enables in the same cycle.

Top module: `cgc_idle_gate`

## Requirements
- R1: While rst_n is low, local_gate_en, trunk_gate_en and aux_gate_en are all 0, whatever the values of idle, tick, gate_mode and aux_gate_dis. This holds even if gating was active when reset was applied.
- R2: Counting starts in the cycle after idle is first sampled high. With min_delay = D, no gating occurs during the first D ticks. The (D+1)-th tick moves the block into the gated state. The enables are visible in the cycle after the clock edge at which that tick is sampled. A D of 1 (0.512 µs) and a D of 255 both follow this rule.
- R3: With min_delay = 0, the first tick after idle rises starts gating.
- R4: If idle falls before the delay has expired, the count is discarded and no enable asserts. The next idle period must again see D+1 ticks.
- R5: In mode 2'b00, trunk_gate_en asserts on the tick that follows the tick that asserted local_gate_en. trunk_gate_en is never high while local_gate_en is low.
- R6: When idle falls, all three enables go to 0 in the same cycle, combinationally, before the next clock edge.
- R7: In mode 2'b10, local_gate_en asserts after the delay, but trunk_gate_en stays 0 no matter how many further ticks arrive.
- R8: In mode 2'b11 and in the reserved mode 2'b01, local_gate_en and trunk_gate_en stay 0.
- R9: aux_gate_en follows the same delay as local_gate_en, regardless of gate_mode, when aux_gate_dis = 0. It stays 0 when aux_gate_dis = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces all gating off |
| idle | input | 1 | Unit idle indication, level |
| tick | input | 1 | One-cycle timebase pulse, one per 0.512 µs |
| min_delay | input | 8 | Minimum idle time in tick periods |
| gate_mode | input | 2 | 00 local+trunk, 10 local only, 11/01 none |
| aux_gate_dis | input | 1 | 1 disables auxiliary clock gating |
| local_gate_en | output | 1 | Gate the main clock at the leaf level |
| trunk_gate_en | output | 1 | Gate the main clock at the trunk |
| aux_gate_en | output | 1 | Gate the auxiliary clock |

## Verification
Some rules are checked by the assertions on every cycle:
- the quiet outputs during reset;
- the immediate removal of every enable when idle is low;
- the trunk enable never standing without the local enable;
- the masking applied by each mode value and by the auxiliary-disable bit.

The exact tick on which gating begins depends on counts the properties do not track, so only the bench's scenarios can show it. These cover delays of 0, 1, 2 and 255, a count restarted after an idle drop, and the one-tick spacing between local and trunk gating.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  typedef enum logic [1:0] {
    CG_RUN   = 2'd0,
    CG_WAIT  = 2'd1,
    CG_LOCAL = 2'd2,
    CG_FULL  = 2'd3
  } cg_state_e;

  localparam logic [1:0] MODE_BOTH       = 2'b00;
  localparam logic [1:0] MODE_LOCAL_ONLY = 2'b10;
endpackage

// File: rtl/cgc_delay_timer.sv
module cgc_delay_timer #(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               tick,
  input  logic [DELAY_W-1:0] limit,
  output logic               expire
);
  logic [DELAY_W-1:0] cnt_q;
  localparam logic [DELAY_W-1:0] CNT_MAX = '1;

  // Ticks seen so far in the current idle period; saturates at its maximum.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // The (limit+1)-th tick ends the wait; >= tolerates a limit lowered mid-count.
  assign expire = tick && !clear && (cnt_q >= limit);
endmodule

// File: rtl/cgc_seq_fsm.sv
module cgc_seq_fsm
  import cgc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idle,
  input  logic      tick,
  input  logic      expire,
  output cg_state_e state,
  output logic      timer_clear
);
  cg_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CG_RUN:   if (idle) state_d = CG_WAIT;
      CG_WAIT:  if (!idle) state_d = CG_RUN;
                else if (expire) state_d = CG_LOCAL;
      CG_LOCAL: if (!idle) state_d = CG_RUN;
                else if (tick) state_d = CG_FULL;
      CG_FULL:  if (!idle) state_d = CG_RUN;
      default:  state_d = CG_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CG_RUN;
    else        state_q <= state_d;
  end

  assign state       = state_q;
  assign timer_clear = (state_q != CG_WAIT);
endmodule

// File: rtl/cgc_gate_decode.sv
module cgc_gate_decode
  import cgc_pkg::*;
(
  input  logic      rst_n,
  input  logic      idle,
  input  cg_state_e state,
  input  logic [1:0] gate_mode,
  input  logic      aux_gate_dis,
  output logic      local_gate_en,
  output logic      trunk_gate_en,
  output logic      aux_gate_en
);
  logic allow_local, allow_trunk, live, past_delay, full_seq;

  assign allow_local = (gate_mode == MODE_BOTH) || (gate_mode == MODE_LOCAL_ONLY);
  assign allow_trunk = (gate_mode == MODE_BOTH);
  // Wake path is combinational on idle and reset so the clock returns at once.
  assign live        = rst_n && idle;
  assign past_delay  = (state == CG_LOCAL) || (state == CG_FULL);
  assign full_seq    = (state == CG_FULL);

  assign local_gate_en = live && past_delay && allow_local;
  assign trunk_gate_en = live && full_seq && allow_trunk;
  assign aux_gate_en   = live && past_delay && !aux_gate_dis;
endmodule

// File: rtl/cgc_idle_gate.sv
module cgc_idle_gate
  import cgc_pkg::*;
#(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idle,
  input  logic               tick,
  input  logic [DELAY_W-1:0] min_delay,
  input  logic [1:0]         gate_mode,
  input  logic               aux_gate_dis,
  output logic               local_gate_en,
  output logic               trunk_gate_en,
  output logic               aux_gate_en
);
  cg_state_e state;
  logic      timer_clear;
  logic      expire;

  cgc_delay_timer #(.DELAY_W(DELAY_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (timer_clear),
    .tick   (tick),
    .limit  (min_delay),
    .expire (expire)
  );

  cgc_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (idle),
    .tick        (tick),
    .expire      (expire),
    .state       (state),
    .timer_clear (timer_clear)
  );

  cgc_gate_decode u_dec (
    .rst_n         (rst_n),
    .idle          (idle),
    .state         (state),
    .gate_mode     (gate_mode),
    .aux_gate_dis  (aux_gate_dis),
    .local_gate_en (local_gate_en),
    .trunk_gate_en (trunk_gate_en),
    .aux_gate_en   (aux_gate_en)
  );
endmodule

// File: rtl/cgc_idle_gate_chk.sv
module cgc_idle_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       idle,
  input logic [1:0] gate_mode,
  input logic       aux_gate_dis,
  input logic       local_gate_en,
  input logic       trunk_gate_en,
  input logic       aux_gate_en
);
  // R1: reset holds every enable low
  always_comb begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!local_gate_en && !trunk_gate_en && !aux_gate_en)
        else $error("R1 enable asserted during reset");
    end
  end

  // R6: idle low means no gating at all
  p_wake_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (!local_gate_en && !trunk_gate_en && !aux_gate_en));

  // R5: trunk only on top of local gating
  p_trunk_needs_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trunk_gate_en |-> local_gate_en);

  // R5: trunk never rises in the same cycle as a fresh local gate
  p_trunk_after_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trunk_gate_en) && $stable(gate_mode)) |-> $past(local_gate_en));

  // R7: local-only mode never gates the trunk
  p_local_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_mode == 2'b10) |-> !trunk_gate_en);

  // R8: modes 11 and 01 gate nothing on the main clock
  p_mode_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_mode[0] |-> (!local_gate_en && !trunk_gate_en));

  // R9: auxiliary disable wins
  p_aux_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aux_gate_dis |-> !aux_gate_en);
endmodule

bind cgc_idle_gate cgc_idle_gate_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .idle          (idle),
  .gate_mode     (gate_mode),
  .aux_gate_dis  (aux_gate_dis),
  .local_gate_en (local_gate_en),
  .trunk_gate_en (trunk_gate_en),
  .aux_gate_en   (aux_gate_en)
);

// File: tb/cgc_idle_gate_tb.sv
`timescale 1ns/1ps
module cgc_idle_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idle = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] min_delay = 8'd1;
  logic [1:0] gate_mode = 2'b00;
  logic       aux_gate_dis = 1'b0;
  logic       local_gate_en, trunk_gate_en, aux_gate_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cgc_idle_gate u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle          (idle),
    .tick          (tick),
    .min_delay     (min_delay),
    .gate_mode     (gate_mode),
    .aux_gate_dis  (aux_gate_dis),
    .local_gate_en (local_gate_en),
    .trunk_gate_en (trunk_gate_en),
    .aux_gate_en   (aux_gate_en)
  );

  task automatic check3(string req, logic el, logic et, logic ea);
    checks++;
    if ({local_gate_en, trunk_gate_en, aux_gate_en} !== {el, et, ea}) begin
      errors++;
      $display("FAIL %s local/trunk/aux actual %b%b%b expected %b%b%b",
               req, local_gate_en, trunk_gate_en, aux_gate_en, el, et, ea);
    end
  endtask

  // Pulse one tick; returns at the negedge after the edge that sampled it.
  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic go_busy();
    idle = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic start_idle();
    idle = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle = 1'b1; gate_mode = 2'b00; aux_gate_dis = 1'b0; min_delay = 8'd0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) pulse_tick();
    check3("R1 reset idle", 1'b0, 1'b0, 1'b0);
    idle = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check3("R1 after release", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_delay(logic [7:0] d);
    go_busy();
    min_delay = d; gate_mode = 2'b00; aux_gate_dis = 1'b0;
    start_idle();
    check3("R2 just idle", 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < d; i++) pulse_tick();
    check3("R2 before delay", 1'b0, 1'b0, 1'b0);
    pulse_tick();
    check3("R2 local after D+1 ticks", 1'b1, 1'b0, 1'b1);
    pulse_tick();
    check3("R5 trunk next tick", 1'b1, 1'b1, 1'b1);
    go_busy();
  endtask

  task automatic t_zero();
    go_busy();
    min_delay = 8'd0; gate_mode = 2'b00;
    start_idle();
    check3("R3 no tick yet", 1'b0, 1'b0, 1'b0);
    pulse_tick();
    check3("R3 first tick gates", 1'b1, 1'b0, 1'b1);
    go_busy();
  endtask

  task automatic t_cancel();
    go_busy();
    min_delay = 8'd3; gate_mode = 2'b00;
    start_idle();
    pulse_tick(); pulse_tick(); pulse_tick();
    idle = 1'b0;
    @(negedge clk);
    pulse_tick();
    check3("R4 cancelled", 1'b0, 1'b0, 1'b0);
    start_idle();
    pulse_tick(); pulse_tick(); pulse_tick();
    check3("R4 count restarted", 1'b0, 1'b0, 1'b0);
    pulse_tick();
    check3("R4 full delay again", 1'b1, 1'b0, 1'b1);
    go_busy();
  endtask

  task automatic t_wake();
    go_busy();
    min_delay = 8'd0; gate_mode = 2'b00;
    start_idle();
    pulse_tick(); pulse_tick();
    check3("R6 fully gated", 1'b1, 1'b1, 1'b1);
    idle = 1'b0;
    #1;
    check3("R6 same-cycle wake", 1'b0, 1'b0, 1'b0);
    go_busy();
  endtask

  task automatic t_reset_mid();
    go_busy();
    min_delay = 8'd0; gate_mode = 2'b00;
    start_idle();
    pulse_tick(); pulse_tick();
    rst_n = 1'b0;
    #1;
    check3("R1 reset while gated", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    idle = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_mode_local();
    go_busy();
    min_delay = 8'd1; gate_mode = 2'b10;
    start_idle();
    pulse_tick(); pulse_tick();
    check3("R7 local only", 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) pulse_tick();
    check3("R7 trunk stays open", 1'b1, 1'b0, 1'b1);
    go_busy();
  endtask

  task automatic t_mode_off(logic [1:0] m);
    go_busy();
    min_delay = 8'd0; gate_mode = m; aux_gate_dis = 1'b0;
    start_idle();
    for (int i = 0; i < 4; i++) pulse_tick();
    check3("R8 no main gating, R9 aux still gates", 1'b0, 1'b0, 1'b1);
    go_busy();
  endtask

  task automatic t_aux_dis();
    go_busy();
    min_delay = 8'd0; gate_mode = 2'b00; aux_gate_dis = 1'b1;
    start_idle();
    pulse_tick(); pulse_tick();
    check3("R9 aux disabled", 1'b1, 1'b1, 1'b0);
    aux_gate_dis = 1'b0;
    #1;
    check3("R9 aux enabled live", 1'b1, 1'b1, 1'b1);
    go_busy();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_delay(8'd1);
    t_delay(8'd2);
    t_delay(8'd255);
    t_zero();
    t_cancel();
    t_wake();
    t_reset_mid();
    t_mode_local();
    t_mode_off(2'b11);
    t_mode_off(2'b01);
    t_aux_dis();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule